// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the scan timing for a TFT raster panel: a pixel clock derived from the system clock by an integer divisor, a one-cycle pixel strobe, horizontal and vertical sync, data enable, the active-area pixel coordinates and an end-of-frame pulse. It generates timing only. The pixel data path is outside it.

The timing comes from three configuration words and a divisor input. Every interval is held in a compact, offset-encoded form, and the wider fields are split across two words. The block turns these into absolute line and frame boundaries. Polarity of each sync and of the pixel clock can be inverted. The syncs can also be moved to the falling pixel-clock edge.

A line is scanned as sync, back porch, active pixels, front porch. The frame follows the same order in lines, and the line counter advances once per completed line. Dropping the enable input stops the scan. Raising it again starts a new frame at its first pixel.

Top module: `lcd_raster_timer`

## Requirements
- R1: Let D be `pclk_div`, with the values 0 and 1 treated as 2. While scanning, `pix_ce` is high for exactly one clock cycle in every D cycles, in the last cycle of each pixel period. The pixel position advances at the clock edge that ends that cycle.
- R2: `pclk` is high for the first floor(D/2) clock cycles of each pixel period and low for the rest. Setting `x_cfg[11]` inverts it.
- R3: The horizontal intervals decode from the configuration words as follows, all in pixels:
  - sync = {x_cfg[7:4], h_cfg[21:16]} + 1
  - back porch = {x_cfg[1:0], h_cfg[7:0]} + 1
  - front porch = {x_cfg[3:2], h_cfg[15:8]} + 1
  - active width = 16 × ({h_cfg[28], h_cfg[27:22]} + 1)
- R4: The vertical intervals decode as follows, all in lines:
  - sync = v_cfg[21:16] + 1
  - back porch = v_cfg[7:0]
  - front porch = v_cfg[15:8]
  - active height = {x_cfg[8], v_cfg[31:22]} + 1
- R5: Each line runs sync, back porch, active, front porch, and each frame runs the same phases in lines. Active-high hsync is asserted during the sync pixels of every line. Active-high vsync is asserted during every pixel of the sync lines.
- R6: `de` is high only when the pixel lies in both the active pixels and the active lines. `px` and `py` give the position within the active area while `de` is high and are zero otherwise.
- R7: `frame_done` is a one-cycle pulse. It is high in the clock cycle in which the scan wraps from the last pixel of the last front-porch line back to pixel 0 of line 0.
- R8: `x_cfg[9]` inverts hsync and `x_cfg[10]` inverts vsync.
- R9: When `x_cfg[12]` is 1 and `x_cfg[13]` is 0, hsync and vsync change at the falling pixel-clock edge, which is floor(D/2) clock cycles after the position changes. Any other setting makes them change at the rising edge, together with the position.
- R10: One cycle after `raster_en` goes low, the block is idle:
  - `pix_ce`, `de` and `frame_done` are low
  - `px` and `py` are zero
  - each sync sits at its inactive level
  - `pclk` sits at its inversion bit

  One cycle after `raster_en` rises, the scan is at pixel 0 of line 0 with the divider at the start of a period.
- R11: While `rst_n` is low, every output is in the idle state of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raster_en | input | 1 | Scan enable |
| pclk_div | input | 8 | Pixel clock divisor |
| h_cfg | input | 29 | Horizontal timing word |
| v_cfg | input | 32 | Vertical timing word |
| x_cfg | input | 14 | High field parts, polarity and edge controls |
| pix_ce | output | 1 | One-cycle strobe per pixel period |
| pclk | output | 1 | Divided pixel clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px | output | 11 | Active-area column |
| py | output | 11 | Active-area row |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
The following outputs change in the clock cycle that follows the `pix_ce` cycle: position, `de`, `px`, `py` and rising-edge syncs. `frame_done` goes high in that same wrap cycle. Falling-edge syncs follow floor(D/2) cycles later. A change of `raster_en` shows one cycle after it is sampled. The bench's reference model advances at each rising clock edge from the inputs seen there. Every output is compared against it at the falling edge in between, so each result is checked in exactly the cycle it is due.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    localparam int DIV_W   = 8;
    localparam int H_CFG_W = 29;
    localparam int V_CFG_W = 32;
    localparam int X_CFG_W = 14;
    localparam int X_W     = 13;
    localparam int Y_W     = 12;
    localparam int PX_W    = 11;

    typedef struct packed {
        logic [X_W-1:0] hsw;
        logic [X_W-1:0] hstart;
        logic [X_W-1:0] hend;
        logic [X_W-1:0] htot_m1;
        logic [Y_W-1:0] vsw;
        logic [Y_W-1:0] vstart;
        logic [Y_W-1:0] vend;
        logic [Y_W-1:0] vtot_m1;
        logic           inv_hs;
        logic           inv_vs;
        logic           inv_pc;
        logic           fall;
    } lcdt_timing_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             run;
    } lcdt_div_t;

    typedef struct packed {
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
        logic           hs_hold;
        logic           vs_hold;
        logic           fd;
    } lcdt_scan_t;
endpackage

// File: rtl/lcdt_decode.sv
module lcdt_decode
    import lcdt_pkg::*;
(
    input  logic [H_CFG_W-1:0] h_cfg,
    input  logic [V_CFG_W-1:0] v_cfg,
    input  logic [X_CFG_W-1:0] x_cfg,
    output lcdt_timing_t       tim
);
    logic [X_W-1:0] hsw, hbp, hfp, wid;
    logic [Y_W-1:0] vsw, vbp, vfp, hgt;

    always_comb begin
        // stored-minus-one horizontal fields, low part plus high part
        hsw = X_W'({x_cfg[7:4], h_cfg[21:16]}) + X_W'(1);
        hbp = X_W'({x_cfg[1:0], h_cfg[7:0]}) + X_W'(1);
        hfp = X_W'({x_cfg[3:2], h_cfg[15:8]}) + X_W'(1);
        wid = (X_W'({h_cfg[28], h_cfg[27:22]}) + X_W'(1)) << 4;
        // vertical porches are stored as-is, sync and height minus one
        vsw = Y_W'(v_cfg[21:16]) + Y_W'(1);
        vbp = Y_W'(v_cfg[7:0]);
        vfp = Y_W'(v_cfg[15:8]);
        hgt = Y_W'({x_cfg[8], v_cfg[31:22]}) + Y_W'(1);

        tim.hsw     = hsw;
        tim.hstart  = hsw + hbp;
        tim.hend    = hsw + hbp + wid;
        tim.htot_m1 = hsw + hbp + wid + hfp - X_W'(1);
        tim.vsw     = vsw;
        tim.vstart  = vsw + vbp;
        tim.vend    = vsw + vbp + hgt;
        tim.vtot_m1 = vsw + vbp + hgt + vfp - Y_W'(1);
        tim.inv_hs  = x_cfg[9];
        tim.inv_vs  = x_cfg[10];
        tim.inv_pc  = x_cfg[11];
        tim.fall    = x_cfg[12] & ~x_cfg[13];
    end
endmodule

// File: rtl/lcdt_pclk.sv
module lcdt_pclk
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             run,
    output logic             pix_ce,
    output logic             half_tick,
    output logic             pclk_raw
);
    lcdt_div_t        s_d, s_q;
    logic [DIV_W-1:0] d_eff, d_m1, half;

    always_comb begin
        d_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
        d_m1  = d_eff - DIV_W'(1);
        half  = d_eff >> 1;

        pix_ce    = s_q.run && (s_q.cnt >= d_m1);
        half_tick = s_q.run && (s_q.cnt == half - DIV_W'(1));
        pclk_raw  = s_q.run && (s_q.cnt < half);
        run       = s_q.run;

        s_d     = s_q;
        s_d.run = en;
        if (!en)
            s_d.cnt = '0;
        else if (s_q.run)
            s_d.cnt = pix_ce ? '0 : s_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);
    // R10
    ce_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !pix_ce && pclk_raw);
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            run,
    input  logic            pix_ce,
    input  logic            half_tick,
    input  logic            pclk_raw,
    input  lcdt_timing_t    tim,
    output logic            pclk,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [PX_W-1:0] px,
    output logic [PX_W-1:0] py,
    output logic            frame_done
);
    lcdt_scan_t     s_d, s_q;
    logic           hs_c, vs_c, hact, vact, last_x, last_y, hs_a, vs_a;
    logic [X_W-1:0] x_off;
    logic [Y_W-1:0] y_off;

    always_comb begin
        hs_c   = s_q.x < tim.hsw;
        vs_c   = s_q.y < tim.vsw;
        hact   = (s_q.x >= tim.hstart) && (s_q.x < tim.hend);
        vact   = (s_q.y >= tim.vstart) && (s_q.y < tim.vend);
        last_x = s_q.x >= tim.htot_m1;
        last_y = s_q.y >= tim.vtot_m1;

        s_d    = s_q;
        s_d.fd = 1'b0;
        if (!en) begin
            s_d = '0;
        end else if (run) begin
            if (half_tick) begin
                s_d.hs_hold = hs_c;
                s_d.vs_hold = vs_c;
            end
            if (pix_ce) begin
                s_d.x = last_x ? '0 : s_q.x + X_W'(1);
                if (last_x) begin
                    s_d.y  = last_y ? '0 : s_q.y + Y_W'(1);
                    s_d.fd = last_y;
                end
            end
        end

        hs_a  = run && (tim.fall ? s_q.hs_hold : hs_c);
        vs_a  = run && (tim.fall ? s_q.vs_hold : vs_c);
        hsync = hs_a ^ tim.inv_hs;
        vsync = vs_a ^ tim.inv_vs;
        pclk  = pclk_raw ^ tim.inv_pc;
        de    = run && hact && vact;
        x_off = s_q.x - tim.hstart;
        y_off = s_q.y - tim.vstart;
        px    = de ? x_off[PX_W-1:0] : '0;
        py    = de ? y_off[PX_W-1:0] : '0;
        frame_done = s_q.fd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    fd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (s_q.x == '0) && (s_q.y == '0));
    // R6
    de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !hs_c);
    // R5
    x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(tim)) |-> s_q.x <= tim.htot_m1);
    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !de && !frame_done && !pix_ce);
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raster_en,
    input  logic [DIV_W-1:0]   pclk_div,
    input  logic [H_CFG_W-1:0] h_cfg,
    input  logic [V_CFG_W-1:0] v_cfg,
    input  logic [X_CFG_W-1:0] x_cfg,
    output logic               pix_ce,
    output logic               pclk,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [PX_W-1:0]    px,
    output logic [PX_W-1:0]    py,
    output logic               frame_done
);
    lcdt_timing_t tim;
    logic         run, half_tick, pclk_raw;

    lcdt_decode u_dec (
        .h_cfg (h_cfg),
        .v_cfg (v_cfg),
        .x_cfg (x_cfg),
        .tim   (tim)
    );

    lcdt_pclk u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (raster_en),
        .div       (pclk_div),
        .run       (run),
        .pix_ce    (pix_ce),
        .half_tick (half_tick),
        .pclk_raw  (pclk_raw)
    );

    lcdt_scan u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (raster_en),
        .run        (run),
        .pix_ce     (pix_ce),
        .half_tick  (half_tick),
        .pclk_raw   (pclk_raw),
        .tim        (tim),
        .pclk       (pclk),
        .hsync      (hsync),
        .vsync      (vsync),
        .de         (de),
        .px         (px),
        .py         (py),
        .frame_done (frame_done)
    );
endmodule

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raster_en = 1'b0;
    logic [7:0]  pclk_div = 8'd2;
    logic [28:0] h_cfg = '0;
    logic [31:0] v_cfg = '0;
    logic [13:0] x_cfg = '0;
    logic        pix_ce, pclk, hsync, vsync, de, frame_done;
    logic [10:0] px, py;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // reference timing, absolute counts
    int t_d, t_half, t_hsw, t_hs0, t_hend, t_htot, t_vsw, t_vs0, t_vend, t_vtot;
    bit t_ihs, t_ivs, t_ipc, t_fall;
    // reference state
    int m_cnt, m_x, m_y;
    bit m_run, m_hh, m_vh, m_fd;

    always #10 clk = ~clk;

    lcd_raster_timer dut (
        .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .pclk_div(pclk_div),
        .h_cfg(h_cfg), .v_cfg(v_cfg), .x_cfg(x_cfg),
        .pix_ce(pix_ce), .pclk(pclk), .hsync(hsync), .vsync(vsync), .de(de),
        .px(px), .py(py), .frame_done(frame_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle=%0d act=%0d exp=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic set_cfg(input int div, input int hsw, input int hbp, input int hfp,
                           input int wid, input int ht, input int vsw, input int vbp,
                           input int vfp, input bit ihs, input bit ivs, input bit ipc,
                           input bit ectl, input bit erise);
        logic [10:0] h, b, f, p, l, s;
        h = 11'(hsw - 1); b = 11'(hbp - 1); f = 11'(hfp - 1);
        p = 11'((wid - 1) >> 4); l = 11'(ht - 1); s = 11'(vsw - 1);
        pclk_div = 8'(div);
        h_cfg = {p[6], p[5:0], h[5:0], f[7:0], b[7:0]};
        v_cfg = {l[9:0], s[5:0], 8'(vfp), 8'(vbp)};
        x_cfg = {erise, ectl, ipc, ivs, ihs, l[10], h[9:6], f[9:8], b[9:8]};
        t_d = (div < 2) ? 2 : div;
        t_half = t_d / 2;
        t_hsw = hsw; t_hs0 = hsw + hbp; t_hend = t_hs0 + wid; t_htot = t_hend + hfp;
        t_vsw = vsw; t_vs0 = vsw + vbp; t_vend = t_vs0 + ht; t_vtot = t_vend + vfp;
        t_ihs = ihs; t_ivs = ivs; t_ipc = ipc; t_fall = ectl && !erise;
    endtask

    // behavioural reference, stepped at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_x = 0; m_y = 0; m_run = 0; m_hh = 0; m_vh = 0; m_fd = 0;
        end else begin
            cyc++;
            if (!raster_en) begin
                m_cnt = 0; m_x = 0; m_y = 0; m_hh = 0; m_vh = 0; m_fd = 0;
            end else begin
                m_fd = 0;
                if (m_run) begin
                    if (m_cnt == t_half - 1) begin
                        m_hh = (m_x < t_hsw);
                        m_vh = (m_y < t_vsw);
                    end
                    if (m_cnt >= t_d - 1) begin
                        m_cnt = 0;
                        if (m_x >= t_htot - 1) begin
                            m_x = 0;
                            if (m_y >= t_vtot - 1) begin
                                m_y = 0; m_fd = 1;
                            end else m_y++;
                        end else m_x++;
                    end else m_cnt++;
                end
            end
            m_run = raster_en;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        bit e_de, e_hs, e_vs;
        e_de = m_run && m_x >= t_hs0 && m_x < t_hend && m_y >= t_vs0 && m_y < t_vend;
        e_hs = m_run && (t_fall ? m_hh : (m_x < t_hsw));
        e_vs = m_run && (t_fall ? m_vh : (m_y < t_vsw));
        if (!rst_n) begin
            chk("R11 reset pix_ce", pix_ce, 0);
            chk("R11 reset de", de, 0);
            chk("R11 reset frame_done", frame_done, 0);
        end else begin
            chk("R1 pix_ce", pix_ce, int'(m_run && m_cnt >= t_d - 1));
            chk("R2 pclk", pclk, int'((m_run && m_cnt < t_half) ^ t_ipc));
            chk("R5 R8 R9 hsync", hsync, int'(e_hs ^ t_ihs));
            chk("R5 R8 R9 vsync", vsync, int'(e_vs ^ t_ivs));
            chk("R3 R4 R6 de", de, int'(e_de));
            chk("R6 px", px, e_de ? m_x - t_hs0 : 0);
            chk("R6 py", py, e_de ? m_y - t_vs0 : 0);
            chk("R7 frame_done", frame_done, int'(m_fd));
            if (!m_run) chk("R10 idle de", de, 0);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(input bit en);
        @(negedge clk);
        raster_en = en;
    endtask

    initial begin
        // R11: reset, basic config
        set_cfg(2, 2, 3, 2, 16, 3, 1, 1, 1, 0, 0, 0, 0, 0);
        run_for(5);
        @(negedge clk); rst_n = 1'b1;
        run_for(3);
        // R1 R2 R3 R4 R5 R6 R7: two frames at divisor 2
        go(1); run_for(620);
        // R10: stop mid frame, then restart at the frame origin
        go(0); run_for(10);
        go(1); run_for(300);
        go(0); run_for(4);
        // R8 R9: odd divisor, inverted outputs, falling-edge syncs, high field parts
        set_cfg(3, 65, 257, 2, 32, 2, 1, 0, 0, 1, 1, 1, 1, 0);
        go(1); run_for(7000);
        go(0); run_for(4);
        // R1 clamp: divisor 1 acts as 2; edge control on with rising edge selected
        set_cfg(1, 3, 1, 4, 16, 2, 2, 0, 2, 0, 0, 1, 1, 1);
        go(1); run_for(500);
        go(0); run_for(4);
        // R1 clamp of 0 as well, brief run
        set_cfg(0, 1, 1, 1, 16, 1, 1, 0, 0, 0, 1, 0, 0, 0);
        go(1); run_for(200);
        go(0); run_for(4);
        // R3: width high bit (1040 pixels)
        set_cfg(2, 4, 2, 3, 1040, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        go(1); run_for(4400);
        go(0); run_for(4);
        // R4: height high bit (1025 lines), full frame and wrap
        set_cfg(2, 2, 3, 2, 16, 1025, 1, 1, 1, 0, 0, 0, 0, 0);
        go(1); run_for(47600);
        go(0); run_for(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule